// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block sits in front of a single-port, byte-lane-organised storage array and behaves like a pipelined synchronous SRAM. Address, chip selects, the two access strobes, the advance input and all write controls are sampled on the rising clock edge. Each sample is decoded into one command: deselect, read, or write. That command is registered. On the following edge it is carried out against the array. Read data lands in an output register and is offered on `rdata_o`. The combinational `drive_o` tells the surrounding pad logic when the data bus may be driven.

An access opens with either the processor strobe or the controller strobe. A processor-strobe start is always a read. A controller-strobe start, and the cycles that follow it, honour the write controls. A global write fills every lane. The byte-lane path writes only the lanes whose selects are low, and only while the byte enable is low.

Later cycles can do one of two things. They can step to an address supplied by an external burst counter when advance is low. Or they can stay on the same address and repeat the previous operation when no strobe and no advance is present. Output enable gates the bus asynchronously. The first read that follows a deselected state is never driven, so that banks sharing a bus do not fight.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: After reset the controller is deselected and `drive_o` is 0 even with `oe_n_i` low. A write command decided at one edge changes the array at the next edge.
- R2: A read decided at edge k puts the addressed word on `rdata_o` after edge k+1. `rdata_o` keeps its value on cycles that carry no read.
- R3: A start with `pstrb_n_i` low and all chip selects active is a read of `addr_i`, even when the write controls request a write. With `cstrb_n_i` low instead, the start is a write when a write is requested and a read otherwise.
- R4: A start (either strobe low) with any chip select inactive is a deselect. Chip selects are active when `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. A deselect writes nothing and drives nothing.
- R5: Byte lane n (bits 8n+7..8n) is written when `bwen_n_i`=0 and `bsel_n_i[n]`=0 in a write cycle. A request counts as a write only if at least one lane is selected. With `bwen_n_i`=1, the lane selects have no effect.
- R6: `gwr_n_i`=0 writes all four lanes, whatever `bwen_n_i` and `bsel_n_i` hold.
- R7: `drive_o` is 1 only while `oe_n_i` is 0. It follows `oe_n_i` without waiting for a clock edge.
- R8: A read whose preceding command was a deselect keeps `drive_o` at 0 for its output cycle. Later reads are driven normally.
- R9: With no strobe and `adv_n_i`=0 in a non-deselected state, the address becomes `burst_addr_i`. The operation is then a write if one is requested, else a read. While deselected, advance and hold cycles stay deselected.
- R10: With no strobe and `adv_n_i`=1, the address is held and the previous operation type is repeated. A repeated write uses the lane controls of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | ADDR_W | Start address |
| burst_addr_i | input | ADDR_W | Next address from the external burst counter |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| pstrb_n_i | input | 1 | Processor access strobe, active low |
| cstrb_n_i | input | 1 | Controller access strobe, active low |
| adv_n_i | input | 1 | Advance to burst address, active low |
| gwr_n_i | input | 1 | Global write, active low |
| bwen_n_i | input | 1 | Byte write enable, active low |
| bsel_n_i | input | LANES | Per-lane write selects, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Output data register |
| drive_o | output | 1 | Data bus may be driven |

## Verification
Two functions can fall in the same cycle. One is the first-read output mask. The other is the asynchronous output-enable gate. Both act on `drive_o` in the output cycle of a read that follows a deselect. The bench holds `oe_n_i` low across a deselect-to-read transition and also toggles `oe_n_i` in the middle of a cycle on a later read. The bench model predicts `drive_o` from both terms each cycle, so it tells a mask that is missing or lasts too long apart from a gate that waits for the clock. A second overlap is a write whose address the very next read hits. The bench's reference array shows whether the read sees the newly written bytes.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] burst_addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              pstrb_n_i,
    input  logic              cstrb_n_i,
    input  logic              adv_n_i,
    input  logic              gwr_n_i,
    input  logic              bwen_n_i,
    input  logic [LANES-1:0]  bsel_n_i,
    input  op_e               prev_op_i,
    input  logic [ADDR_W-1:0] prev_addr_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  lanes_o,
    output logic              first_o
);
    logic start;
    logic sel;
    logic wreq;

    always_comb begin
        start   = !pstrb_n_i || !cstrb_n_i;
        sel     = !cs1_n_i && cs2_i && !cs3_n_i;
        lanes_o = !gwr_n_i ? '1 : (!bwen_n_i ? ~bsel_n_i : '0);
        wreq    = (lanes_o != '0);
        op_o    = prev_op_i;
        addr_o  = prev_addr_i;
        if (start) begin
            if (!sel) begin
                op_o = OP_DESEL;
            end else begin
                addr_o = addr_i;
                op_o   = (!pstrb_n_i || !wreq) ? OP_READ : OP_WRITE;
            end
        end else if (prev_op_i == OP_DESEL) begin
            op_o = OP_DESEL;
        end else if (!adv_n_i) begin
            addr_o = burst_addr_i;
            op_o   = wreq ? OP_WRITE : OP_READ;
        end
        first_o = (op_o == OP_READ) && (prev_op_i == OP_DESEL);
    end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LANES-1:0]         lanes_i,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    output logic [LANES*LANE_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_i && lanes_i[g]) begin
                mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
            if (rd_i) begin
                q <= mem[addr_i];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
    import sram_pipe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [ADDR_W-1:0]       burst_addr_i,
    input  logic                    cs1_n_i,
    input  logic                    cs2_i,
    input  logic                    cs3_n_i,
    input  logic                    pstrb_n_i,
    input  logic                    cstrb_n_i,
    input  logic                    adv_n_i,
    input  logic                    gwr_n_i,
    input  logic                    bwen_n_i,
    input  logic [LANES-1:0]        bsel_n_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    oe_n_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    drive_o
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] wdata;
        logic              first;
        logic              rd_valid;
        logic              rd_mask;
    } state_t;

    state_t            st_d, st_q;
    op_e               dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic [LANES-1:0]  dec_lanes;
    logic              dec_first;
    op_e               cur_op;

    sram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
        .addr_i      (addr_i),
        .burst_addr_i(burst_addr_i),
        .cs1_n_i     (cs1_n_i),
        .cs2_i       (cs2_i),
        .cs3_n_i     (cs3_n_i),
        .pstrb_n_i   (pstrb_n_i),
        .cstrb_n_i   (cstrb_n_i),
        .adv_n_i     (adv_n_i),
        .gwr_n_i     (gwr_n_i),
        .bwen_n_i    (bwen_n_i),
        .bsel_n_i    (bsel_n_i),
        .prev_op_i   (st_q.op),
        .prev_addr_i (st_q.addr),
        .op_o        (dec_op),
        .addr_o      (dec_addr),
        .lanes_o     (dec_lanes),
        .first_o     (dec_first)
    );

    always_comb begin
        st_d          = st_q;
        st_d.op       = dec_op;
        st_d.addr     = dec_addr;
        st_d.lanes    = dec_lanes;
        st_d.wdata    = wdata_i;
        st_d.first    = dec_first;
        st_d.rd_valid = (st_q.op == OP_READ);
        st_d.rd_mask  = st_q.first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_DESEL;
        end else begin
            st_q <= st_d;
        end
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .wr_i   (st_q.op == OP_WRITE),
        .rd_i   (st_q.op == OP_READ),
        .addr_i (st_q.addr),
        .lanes_i(st_q.lanes),
        .wdata_i(st_q.wdata),
        .rdata_o(rdata_o)
    );

    assign cur_op  = st_q.op;
    assign drive_o = !oe_n_i && st_q.rd_valid && !st_q.rd_mask;
endmodule

// File: rtl/sram_pipe_ctrl_chk.sv
module sram_pipe_ctrl_chk
    import sram_pipe_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic cs1_n_i,
    input logic cs2_i,
    input logic cs3_n_i,
    input logic pstrb_n_i,
    input logic cstrb_n_i,
    input logic oe_n_i,
    input logic drive_o,
    input op_e  cur_op
);
    logic sel;
    assign sel = !cs1_n_i && cs2_i && !cs3_n_i;

    assert_proc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n_i && sel) |=> (cur_op == OP_READ));

    assert_desel_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pstrb_n_i || !cstrb_n_i) && !sel) |=> (cur_op == OP_DESEL));

    assert_write_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_WRITE) |=> !drive_o);

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> !oe_n_i);

    assert_first_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_op == OP_READ) && ($past(cur_op) == OP_DESEL)) |=> !drive_o);

    assert_desel_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_op == OP_DESEL) && pstrb_n_i && cstrb_n_i) |=> (cur_op == OP_DESEL));
endmodule

bind sram_pipe_ctrl sram_pipe_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs1_n_i  (cs1_n_i),
    .cs2_i    (cs2_i),
    .cs3_n_i  (cs3_n_i),
    .pstrb_n_i(pstrb_n_i),
    .cstrb_n_i(cstrb_n_i),
    .oe_n_i   (oe_n_i),
    .drive_o  (drive_o),
    .cur_op   (cur_op)
);

// File: tb/sram_pipe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_pipe_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  addr_i = 0, burst_addr_i = 0;
    logic        cs1_n_i, cs2_i, cs3_n_i, pstrb_n_i, cstrb_n_i, adv_n_i;
    logic        gwr_n_i, bwen_n_i, oe_n_i;
    logic [3:0]  bsel_n_i;
    logic [31:0] wdata_i = 0;
    logic [31:0] rdata_o;
    logic        drive_o;

    int    total = 0, bad = 0;
    string phase = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    sram_pipe_ctrl u_dut (.*);

    // reference model: 0 deselect, 1 read, 2 write
    int          m_op, m_addr, m_lanes, m_first;
    logic [31:0] m_wd;
    logic [31:0] mem [int];
    int          ev, em;
    logic [31:0] er;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_op = 0; m_addr = 0; m_lanes = 0; m_first = 0; ev = 0; em = 0;
        end else begin
            int prev, ln, wq, sel, start;
            ev = 0;
            if (m_op == 2) begin
                if (!mem.exists(m_addr)) mem[m_addr] = 'x;
                for (int i = 0; i < 4; i++)
                    if (m_lanes[i]) mem[m_addr][8*i +: 8] = m_wd[8*i +: 8];
            end else if (m_op == 1) begin
                ev = 1; em = m_first;
                er = mem.exists(m_addr) ? mem[m_addr] : 'x;
            end
            prev  = m_op;
            sel   = (!cs1_n_i && cs2_i && !cs3_n_i);
            start = (!pstrb_n_i || !cstrb_n_i);
            ln    = !gwr_n_i ? 15 : (!bwen_n_i ? int'(~bsel_n_i) : 0);
            wq    = (ln != 0);
            if (start) begin
                if (!sel) m_op = 0;
                else begin
                    m_addr = addr_i;
                    m_op = (!pstrb_n_i || !wq) ? 1 : 2;
                end
            end else if (prev == 0) m_op = 0;
            else if (!adv_n_i) begin
                m_addr = burst_addr_i;
                m_op = wq ? 2 : 1;
            end
            m_lanes = ln; m_wd = wdata_i;
            m_first = (m_op == 1 && prev == 0);
        end
    end

    function automatic logic exp_drive();
        return !oe_n_i && ev != 0 && em == 0;
    endfunction

    task automatic chk_drive(string tag);
        total++;
        if (drive_o !== exp_drive()) begin
            bad++;
            $display("FAIL %s: drive_o=%0b expected %0b", tag, drive_o, exp_drive());
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk_drive(phase);
            if (ev != 0 && !$isunknown(er)) begin
                total++;
                if (rdata_o !== er) begin
                    bad++;
                    $display("FAIL %s: rdata_o=%h expected %h", phase, rdata_o, er);
                end
            end
        end
    end

    task automatic idle();
        pstrb_n_i = 1; cstrb_n_i = 1; adv_n_i = 1; gwr_n_i = 1; bwen_n_i = 1;
        bsel_n_i = 4'hF; cs1_n_i = 0; cs2_i = 1; cs3_n_i = 0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic cstart(input logic [7:0] a, input logic [31:0] d,
                          input logic g_n, input logic b_n, input logic [3:0] s_n);
        idle(); cstrb_n_i = 0; addr_i = a; wdata_i = d;
        gwr_n_i = g_n; bwen_n_i = b_n; bsel_n_i = s_n;
        tick(); idle();
    endtask

    task automatic pread(input logic [7:0] a);
        idle(); pstrb_n_i = 0; addr_i = a; tick(); idle();
    endtask

    initial begin
        idle(); oe_n_i = 0;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (drive_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: drive_o=%0b expected 0 in reset", drive_o);
        end
        rst_n = 1;
        tick(); tick();

        phase = "R6";
        for (int a = 0; a < 16; a++) cstart(8'(a), 32'h1000_0000 * a + 32'h0102_0304 * a, 0, 1, 4'hF);
        for (int a = 32; a < 40; a++) cstart(8'(a), 32'hA5A5_0000 + a, 0, 0, 4'hE);
        cstart(8'd5, 32'hDEAD_BEEF, 0, 0, 4'hF);
        pread(8'd5); tick();

        phase = "R5";
        cstart(8'd2, 32'h1122_3344, 1, 0, 4'b1010);
        pread(8'd2); tick();
        cstart(8'd3, 32'hFFFF_FFFF, 1, 1, 4'h0);
        pread(8'd3); tick();

        phase = "R3";
        idle(); pstrb_n_i = 0; addr_i = 8'd4; gwr_n_i = 0; wdata_i = 32'h0BAD_0BAD; tick(); idle();
        pread(8'd4); tick();

        phase = "R2";
        pread(8'd1); pread(8'd2); pread(8'd3);
        cstart(8'd6, 32'h6666_7777, 0, 1, 4'hF);
        pread(8'd6); tick(); tick();

        phase = "R7";
        #1; oe_n_i = 1; #1; chk_drive("R7");
        oe_n_i = 0; #1; chk_drive("R7");
        tick();

        phase = "R8";
        idle(); cstrb_n_i = 0; cs2_i = 0; tick(); idle();
        tick();
        pread(8'd7); tick(); tick();
        idle(); pstrb_n_i = 0; cs1_n_i = 1; tick(); idle();
        cstart(8'd8, 32'h8888_0001, 1, 1, 4'hF);
        tick();

        phase = "R9";
        idle(); pstrb_n_i = 0; cs3_n_i = 1; tick(); idle();
        adv_n_i = 0; burst_addr_i = 8'd33; tick();
        gwr_n_i = 0; burst_addr_i = 8'd34; wdata_i = 32'h0; tick(); idle();
        pread(8'd32);
        adv_n_i = 0; burst_addr_i = 8'd33; tick();
        burst_addr_i = 8'd34; gwr_n_i = 0; wdata_i = 32'h3434_3434; tick();
        gwr_n_i = 1; burst_addr_i = 8'd35; tick(); idle();
        pread(8'd34); tick();

        phase = "R10";
        cstart(8'd9, 32'h9999_9999, 0, 1, 4'hF);
        bwen_n_i = 0; bsel_n_i = 4'b0111; wdata_i = 32'h5A00_0000; tick(); idle();
        tick();
        pread(8'd9); tick(); tick();

        phase = "R4";
        idle(); cstrb_n_i = 0; cs1_n_i = 1; gwr_n_i = 0; addr_i = 8'd10; wdata_i = 32'h0; tick();
        idle(); cstrb_n_i = 0; cs2_i = 0; gwr_n_i = 0; addr_i = 8'd11; tick();
        idle(); cstrb_n_i = 0; cs3_n_i = 1; gwr_n_i = 0; addr_i = 8'd12; tick(); idle();
        pread(8'd10); pread(8'd11); pread(8'd12); tick(); tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule